// File: doc/BRIEF.md
# Cascaded FIFO Depth Expansion Chain

This block joins a configurable number of identical first-word-fall-through buffer stages so that together they act as one deeper FIFO. Each stage signals, active low, that it holds a readable word and that it has room for another word. Between neighbours, the upstream stage's readable flag acts as the downstream stage's write enable. The downstream stage's room flag acts as the upstream stage's read enable. Words therefore drain toward the tail on their own, and free slots travel toward the head when the chain is full.

A single clock serves as the write, read and transfer clock. Every stage has fixed internal handshake delays. A word written into an empty stage becomes readable three edges later. A slot freed by a read counts as free again two edges later. Because these delays add up, the first word entering an empty chain and the first slot freed in a full chain both take a time that grows linearly with the number of stages. Once a word has arrived, later words follow at one per cycle.

Top module: `dxc_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every stage is emptied. Afterwards `out_rdy_n` is 1 (nothing readable) and `in_rdy_n` is 0 (space available).
- R2: A write takes effect at a rising edge only when `wr_en_n` is 0 and `in_rdy_n` is 0. A write attempted while `in_rdy_n` is 1 leaves the contents unchanged and adds no word to the output stream.
- R3: A read attempted while `out_rdy_n` is 1 has no effect. It neither removes nor reorders any word that is written later.
- R4: Whenever `out_rdy_n` is 0, `rd_data` shows the oldest stored word. A read (`rd_en_n` 0 while `out_rdy_n` is 0) removes that word at the edge. Words leave in exactly the order they were accepted.
- R5: The chain accepts exactly STAGES × STAGE_DEPTH words with no reads. After that, `in_rdy_n` stays 1, and no stage ever holds more than STAGE_DEPTH words.
- R6: When a word is written into an empty chain at edge E, `out_rdy_n` first reads 0 after edge E + 3 + 4·(STAGES−1).
- R7: When one word is read from a full chain at edge E, `in_rdy_n` first reads 0 after edge E + 2 + 3·(STAGES−1).
- R8: Words written on consecutive edges into an empty chain reach the tail on consecutive cycles. A tail read on every cycle from the first readable cycle finds `out_rdy_n` at 0 for each of those words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common write, read and transfer clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | WIDTH | Word presented to the head stage |
| wr_en_n | input | 1 | Write request, active low |
| in_rdy_n | output | 1 | Head has room, active low |
| rd_data | output | WIDTH | Oldest word at the tail (fall-through) |
| rd_en_n | input | 1 | Read request, active low |
| out_rdy_n | output | 1 | Tail holds a readable word, active low |

## Verification
The per-stage assertions assume that reset is held for at least one edge before traffic starts. They also assume that `wr_en_n` and `rd_en_n` always carry defined levels. Beyond that, the assertions treat a request made against a busy flag as legal input that must simply be ignored. The stimulus asserts reset first and changes every input only on the falling clock edge, so each request is stable at the edge that samples it. It deliberately issues writes against a full chain and reads against an empty one, alongside random traffic phases biased toward filling and toward draining.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
    // Edges from an accepted write until the word is readable at the same stage.
    localparam int FILL_LAT = 3;
    // Edges from an accepted read until the slot counts as free again.
    localparam int FREE_LAT = 2;
endpackage

// File: rtl/dxc_delay.sv
module dxc_delay #(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    output logic pulse_o
);
    logic [LEN-1:0] sh_d;
    logic [LEN-1:0] sh_q;

    generate
        if (LEN == 1) begin : g_one
            always_comb sh_d = pulse_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[LEN-2:0], pulse_i};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign pulse_o = sh_q[LEN-1];
endmodule

// File: rtl/dxc_stage.sv
module dxc_stage
    import dxc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             wen_n,
    output logic             ir_n,
    output logic [WIDTH-1:0] dout,
    input  logic             ren_n,
    output logic             or_n
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;     // next slot to write
        logic [AW-1:0] rp;     // slot shown on dout
        logic [CW-1:0] held;   // slots in use, seen by the write side
        logic [CW-1:0] avail;  // words readable, seen by the read side
    } stage_t;

    stage_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic wr_ok, rd_ok, fill_tap, free_tap;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign ir_n  = (s_q.held == CW'(DEPTH));
    assign or_n  = (s_q.avail == '0);
    assign dout  = mem_q[s_q.rp];
    assign wr_ok = !wen_n && !ir_n;
    assign rd_ok = !ren_n && !or_n;

    dxc_delay #(.LEN(FILL_LAT)) u_fill (
        .clk(clk), .rst(rst), .pulse_i(wr_ok), .pulse_o(fill_tap)
    );
    dxc_delay #(.LEN(FREE_LAT)) u_free (
        .clk(clk), .rst(rst), .pulse_i(rd_ok), .pulse_o(free_tap)
    );

    always_comb begin
        s_d = s_q;
        if (wr_ok) s_d.wp = bump(s_q.wp);
        if (rd_ok) s_d.rp = bump(s_q.rp);
        s_d.held  = s_q.held + CW'(wr_ok) - CW'(free_tap);
        s_d.avail = s_q.avail + CW'(fill_tap) - CW'(rd_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[s_q.wp] <= din;
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (or_n && !ir_n));
    // R2
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!wen_n && ir_n) |=> $stable(s_q.wp));
    // R3
    ignored_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!ren_n && or_n) |=> $stable(s_q.rp));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.held <= CW'(DEPTH));
    // R4
    avail_within_held_chk: assert property (@(posedge clk) disable iff (rst)
        s_q.avail <= s_q.held);
endmodule

// File: rtl/dxc_chain.sv
module dxc_chain #(
    parameter int STAGES      = 4,
    parameter int STAGE_DEPTH = 16,
    parameter int WIDTH       = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_en_n,
    output logic             in_rdy_n,
    output logic [WIDTH-1:0] rd_data,
    input  logic             rd_en_n,
    output logic             out_rdy_n
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] st_din  [STAGES];
    logic [WIDTH-1:0] st_dout [STAGES];
    logic             st_wen_n[STAGES];
    logic             st_ren_n[STAGES];
    logic             st_ir_n [STAGES];
    logic             st_or_n [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_head
                assign st_din[k]   = wr_data;
                assign st_wen_n[k] = wr_en_n;
            end else begin : g_link_in
                // upstream readable flag doubles as this stage's write enable
                assign st_din[k]   = st_dout[k-1];
                assign st_wen_n[k] = st_or_n[k-1];
            end
            if (k == LAST) begin : g_tail
                assign st_ren_n[k] = rd_en_n;
            end else begin : g_link_out
                // downstream room flag doubles as this stage's read enable
                assign st_ren_n[k] = st_ir_n[k+1];
            end

            dxc_stage #(.DEPTH(STAGE_DEPTH), .WIDTH(WIDTH)) u_stage (
                .clk  (clk),
                .rst  (rst),
                .din  (st_din[k]),
                .wen_n(st_wen_n[k]),
                .ir_n (st_ir_n[k]),
                .dout (st_dout[k]),
                .ren_n(st_ren_n[k]),
                .or_n (st_or_n[k])
            );
        end
    endgenerate

    assign in_rdy_n  = st_ir_n[0];
    assign rd_data   = st_dout[LAST];
    assign out_rdy_n = st_or_n[LAST];
endmodule

// File: tb/dxc_chain_test.sv
module dxc_chain_test;
    localparam int D = 8;
    localparam int W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] wdata = '0;
    logic         wen_n [3];
    logic         ren_n [3];
    logic         ir_n  [3];
    logic         or_n  [3];
    logic [W-1:0] rdat  [3];

    dxc_chain #(.STAGES(4), .STAGE_DEPTH(D), .WIDTH(W)) uut (
        .clk(clk), .rst(rst), .wr_data(wdata), .wr_en_n(wen_n[0]), .in_rdy_n(ir_n[0]),
        .rd_data(rdat[0]), .rd_en_n(ren_n[0]), .out_rdy_n(or_n[0]));
    dxc_chain #(.STAGES(2), .STAGE_DEPTH(D), .WIDTH(W)) uut_n2 (
        .clk(clk), .rst(rst), .wr_data(wdata), .wr_en_n(wen_n[1]), .in_rdy_n(ir_n[1]),
        .rd_data(rdat[1]), .rd_en_n(ren_n[1]), .out_rdy_n(or_n[1]));
    dxc_chain #(.STAGES(1), .STAGE_DEPTH(D), .WIDTH(W)) uut_n1 (
        .clk(clk), .rst(rst), .wr_data(wdata), .wr_en_n(wen_n[2]), .in_rdy_n(ir_n[2]),
        .rd_data(rdat[2]), .rd_en_n(ren_n[2]), .out_rdy_n(or_n[2]));

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    logic [W-1:0] refq [3][64];
    int rh [3];
    int rc [3];
    int acc[3];
    int pops[3];

    function automatic int nst(input int i);
        return (i == 0) ? 4 : (i == 1) ? 2 : 1;
    endfunction
    function automatic int fill_lat(input int n);
        return 3 + 4 * (n - 1);
    endfunction
    function automatic int free_lat(input int n);
        return 2 + 3 * (n - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts and ends just after a falling edge; one rising edge in between.
    task automatic cycle_do(input logic [2:0] w, input logic [2:0] r, input logic [W-1:0] d);
        wdata = d;
        for (int i = 0; i < 3; i++) begin
            wen_n[i] = ~w[i];
            ren_n[i] = ~r[i];
            if (w[i] && !ir_n[i]) begin
                refq[i][(rh[i] + rc[i]) % 64] = d;
                rc[i]++;
                acc[i]++;
            end
            if (r[i] && !or_n[i]) begin
                // R4: fall-through word must be the oldest accepted one
                chk(rdat[i] == refq[i][rh[i]], "R4 order", int'(rdat[i]), int'(refq[i][rh[i]]));
                rh[i] = (rh[i] + 1) % 64;
                rc[i]--;
                pops[i]++;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 3; i++) begin
            acc[i] = 0;
            pops[i] = 0;
        end
    endtask

    task automatic drain(input string req);
        for (int c = 0; c < 200; c++) cycle_do(3'b000, 3'b111, '0);
        for (int i = 0; i < 3; i++) begin
            chk(rc[i] == 0, req, rc[i], 0);
            chk(or_n[i] == 1'b1, req, int'(or_n[i]), 1);
        end
    endtask

    initial begin
        int lat[3];
        int got[3];
        bit started[3];
        int unsigned seed_sink;
        logic [2:0] w, r;
        seed_sink = $urandom(32'd2024);
        for (int i = 0; i < 3; i++) begin
            wen_n[i] = 1'b1; ren_n[i] = 1'b1; rh[i] = 0; rc[i] = 0;
        end
        clear_counts();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            chk(or_n[i] == 1'b1, "R1 out_rdy_n", int'(or_n[i]), 1);
            chk(ir_n[i] == 1'b0, "R1 in_rdy_n", int'(ir_n[i]), 0);
        end

        // R3: reads against an empty chain
        for (int c = 0; c < 4; c++) cycle_do(3'b000, 3'b111, '0);
        for (int i = 0; i < 3; i++) chk(or_n[i] == 1'b1, "R3 empty stays empty", int'(or_n[i]), 1);

        // R6: ripple-down latency into an empty chain
        cycle_do(3'b111, 3'b000, 18'h2A5A5);
        for (int i = 0; i < 3; i++) lat[i] = -1;
        for (int t = 1; t <= 40; t++) begin
            cycle_do(3'b000, 3'b000, '0);
            for (int i = 0; i < 3; i++) if (lat[i] < 0 && !or_n[i]) lat[i] = t;
        end
        for (int i = 0; i < 3; i++) chk(lat[i] == fill_lat(nst(i)), "R6 fill latency", lat[i], fill_lat(nst(i)));
        // R3: first word out is the first written despite the earlier empty reads
        for (int i = 0; i < 3; i++) chk(rdat[i] == 18'h2A5A5, "R3 first word", int'(rdat[i]), 'h2A5A5);
        cycle_do(3'b000, 3'b111, '0);

        // R8: burst of four streams out back to back
        for (int c = 0; c < 4; c++) cycle_do(3'b111, 3'b000, 18'(100 + c));
        for (int i = 0; i < 3; i++) begin got[i] = 0; started[i] = 0; end
        for (int c = 0; c < 40; c++) begin
            r = '0;
            for (int i = 0; i < 3; i++) begin
                if (!or_n[i]) started[i] = 1;
                if (started[i] && got[i] < 4) begin
                    chk(or_n[i] == 1'b0, "R8 stream gap", int'(or_n[i]), 0);
                    r[i] = 1'b1;
                    got[i]++;
                end
            end
            cycle_do(3'b000, r, '0);
        end
        for (int i = 0; i < 3; i++) chk(got[i] == 4 && rc[i] == 0, "R8 burst count", got[i], 4);

        // R5: fill with no reads, writes keep being attempted while full (R2)
        clear_counts();
        for (int c = 0; c < 150; c++) cycle_do(3'b111, 3'b000, 18'($urandom));
        for (int i = 0; i < 3; i++) begin
            chk(acc[i] == nst(i) * D, "R5 capacity", acc[i], nst(i) * D);
            chk(ir_n[i] == 1'b1, "R5 full flag", int'(ir_n[i]), 1);
        end

        // R7: bubble-up latency after one tail read
        cycle_do(3'b000, 3'b111, '0);
        for (int i = 0; i < 3; i++) lat[i] = -1;
        for (int t = 1; t <= 40; t++) begin
            cycle_do(3'b000, 3'b000, '0);
            for (int i = 0; i < 3; i++) if (lat[i] < 0 && !ir_n[i]) lat[i] = t;
        end
        for (int i = 0; i < 3; i++) chk(lat[i] == free_lat(nst(i)), "R7 free latency", lat[i], free_lat(nst(i)));

        // R2: drained total equals accepted total, so full-time writes added nothing
        clear_counts();
        drain("R2 nothing extra after full writes");
        for (int i = 0; i < 3; i++) chk(pops[i] == nst(i) * D - 1, "R2 drained count", pops[i], nst(i) * D - 1);

        // R4: random traffic, alternating fill-biased and drain-biased phases
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < 3; i++) begin
                if (((c / 400) % 2) == 0) begin
                    w[i] = ($urandom % 4) != 0;
                    r[i] = ($urandom % 4) == 0;
                end else begin
                    w[i] = ($urandom % 4) == 0;
                    r[i] = ($urandom % 4) != 0;
                end
            end
            cycle_do(w, r, 18'($urandom));
        end
        drain("R4 final drain");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog (R1..R8 run) actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule